// File: doc/BRIEF.md
# Multi-Target Interrupt Status Aggregator

This block collects a set of interrupt sources into one 32-bit status word and fans that word out to eight interrupt outputs. Each output has its own enable word, and an output is raised whenever some status bit is set and also enabled in that output's word. One status bit position carries the summary line of a GPIO bank. Turning that bit on or off in an enable word routes GPIO interrupts to that output or keeps them away from it.

Two status bits are not tied to any hardware line. Software sets them by writing the status word, which lets the whole path from status through enable to output be exercised without touching the sources. Writing zero to the status word acknowledges the block by clearing these bits. The other status bits copy their source lines on every clock. Register writes do not change them, so a hardware interrupt stays pending until its source line drops.

Registers are accessed through a simple single-cycle port. Status is at address 0. Enable word n is at address 8+n. All other addresses read as zero and ignore writes.

Top module: `irq_fanout_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all eight enable words read zero, both software status bits are zero and every bit of `irq_o` is low.
- R2: Every status bit other than bits 2 and 3 is a registered copy of the matching `src_i` bit. It updates on the clock edge that samples `src_i`. The GPIO bank summary arrives on `src_i[15]` and is status bit 15.
- R3: A write to the status word (address 0) leaves every hardware status bit, meaning every bit except 2 and 3, at its source value.
- R4: A write to the status word loads bits 2 and 3 of the write data into software status bits 2 and 3. Writing zero therefore clears both of them, and they keep their value when no status write occurs.
- R5: `src_i[2]` and `src_i[3]` have no effect on the status word or on `irq_o`.
- R6: Enable word n (n = 0..7) is read and written as a full 32-bit value at address 8+n. A write to one enable word leaves the other seven unchanged.
- R7: `irq_o[n]` is high exactly when the registered status word ANDed with enable word n is nonzero. It reflects the registers with no extra delay.
- R8: Setting or clearing bit 15 in enable word n turns routing of the GPIO summary (`src_i[15]`) to `irq_o[n]` on or off, independently for each output.
- R9: Reads from addresses 1 to 7 return zero. Writes to those addresses change neither any enable word nor the software status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| src_i | input | 32 | Interrupt source lines, already synchronous to `clk`; bit 15 is the GPIO summary |
| irq_o | output | 8 | One interrupt output per enable word |

## Verification
Source changes, status writes and enable-word writes each take effect on the first rising edge after they are presented. Read data and `irq_o` then follow in the same cycle through logic only. The bench drives every stimulus on a falling edge and checks on the next falling edge, so exactly one rising edge lies between cause and check. Register reads are sampled one time unit after the address is set, while the design is in the same cycle.

// File: rtl/irqf_pkg.sv
// Shared constants and types for the interrupt aggregator.
// Assumes a single clock domain; sources arrive already synchronised.
package irqf_pkg;
    localparam int STAT_W_DEF   = 32;
    localparam int N_TGT_DEF    = 8;
    localparam int GPIO_BIT_DEF = 15;
    localparam int SW_LO_DEF    = 2;
    localparam int SW_N_DEF     = 2;

    // Which register the current address selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CFG  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irqf_status.sv
// Status word register.
// Hardware bits copy src_i every cycle. Software bits (SW_MASK) change only
// when a status write loads them from the write data.
// Assumes src_i is synchronous to clk.
module irqf_status #(
    parameter int               STAT_W  = 32,
    parameter logic [STAT_W-1:0] SW_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] src_i,
    input  logic              wr_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] stat_o
);
    localparam logic [STAT_W-1:0] HW_MASK = ~SW_MASK;

    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] sw_next;

    // Choose the next software bits: load them on a write, otherwise keep them.
    always_comb begin
        if (wr_i) sw_next = wdata_i & SW_MASK;
        else      sw_next = stat_q & SW_MASK;
    end

    // Register the hardware copy together with the software bits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (src_i & HW_MASK) | sw_next;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/irqf_cfg_bank.sv
// Bank of N_TGT enable words, each STAT_W wide, written by index.
// Assumes wr_i is asserted only when idx_i selects a valid word.
module irqf_cfg_bank #(
    parameter int STAT_W = 32,
    parameter int N_TGT  = 8,
    localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [STAT_W-1:0]       wdata_i,
    output logic [N_TGT*STAT_W-1:0] cfg_o
);
    for (genvar g = 0; g < N_TGT; g++) begin : g_word
        logic [STAT_W-1:0] word_q;
        logic              hit;

        // Decode whether this word is the write target.
        always_comb hit = wr_i && (idx_i == IDX_W'(g));

        // Hold the enable word and load it when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)   word_q <= '0;
            else if (hit) word_q <= wdata_i;
        end

        assign cfg_o[g*STAT_W +: STAT_W] = word_q;
    end
endmodule

// File: rtl/irqf_target_or.sv
// Per-output reduction: output n is high when status AND enable word n is
// nonzero. Purely combinational; assumes both inputs are registered upstream.
module irqf_target_or #(
    parameter int STAT_W = 32,
    parameter int N_TGT  = 8
) (
    input  logic [STAT_W-1:0]       stat_i,
    input  logic [N_TGT*STAT_W-1:0] cfg_i,
    output logic [N_TGT-1:0]        irq_o
);
    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
        logic [STAT_W-1:0] masked;

        // Gate the status word with this output's enable word.
        always_comb masked = stat_i & cfg_i[g*STAT_W +: STAT_W];

        assign irq_o[g] = |masked;
    end
endmodule

// File: rtl/irq_fanout_ctrl.sv
// Top of the interrupt aggregator: decodes the register port, holds the status
// word and the enable bank, and drives one interrupt per enable word.
// Map: address 0 = status, addresses CFG_BASE..CFG_BASE+N_TGT-1 = enable words,
// all others read zero. Assumes N_TGT is a power of two.
module irq_fanout_ctrl #(
    parameter int STAT_W   = irqf_pkg::STAT_W_DEF,
    parameter int N_TGT    = irqf_pkg::N_TGT_DEF,
    parameter int GPIO_BIT = irqf_pkg::GPIO_BIT_DEF,
    parameter int SW_LO    = irqf_pkg::SW_LO_DEF,
    parameter int SW_N     = irqf_pkg::SW_N_DEF,
    localparam int ADDR_W  = $clog2(2 * N_TGT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [STAT_W-1:0] reg_wdata_i,
    output logic [STAT_W-1:0] reg_rdata_o,
    input  logic [STAT_W-1:0] src_i,
    output logic [N_TGT-1:0]  irq_o
);
    import irqf_pkg::*;

    localparam int IDX_W    = (N_TGT > 1) ? $clog2(N_TGT) : 1;
    localparam int CFG_BASE = N_TGT;
    localparam logic [STAT_W-1:0] SW_MASK =
        ((STAT_W'(1) << SW_N) - STAT_W'(1)) << SW_LO;
    localparam logic [STAT_W-1:0] GPIO_MASK = STAT_W'(1) << GPIO_BIT;

    reg_sel_e                sel;
    logic [IDX_W-1:0]        cfg_idx;
    logic [STAT_W-1:0]       stat_q;
    logic [N_TGT*STAT_W-1:0] cfg_flat;
    logic                    stat_wr;
    logic                    cfg_wr;

    // Decode the register address into a target and an enable-word index.
    always_comb begin
        cfg_idx = IDX_W'(reg_addr_i - ADDR_W'(CFG_BASE));
        if (reg_addr_i == '0)
            sel = SEL_STAT;
        else if (reg_addr_i >= ADDR_W'(CFG_BASE))
            sel = SEL_CFG;
        else
            sel = SEL_NONE;
    end

    // Steer the write strobe to the selected register.
    always_comb begin
        stat_wr = reg_wr_i && (sel == SEL_STAT);
        cfg_wr  = reg_wr_i && (sel == SEL_CFG);
    end

    irqf_status #(
        .STAT_W  (STAT_W),
        .SW_MASK (SW_MASK)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .wr_i    (stat_wr),
        .wdata_i (reg_wdata_i),
        .stat_o  (stat_q)
    );

    irqf_cfg_bank #(
        .STAT_W (STAT_W),
        .N_TGT  (N_TGT)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .idx_i   (cfg_idx),
        .wdata_i (reg_wdata_i),
        .cfg_o   (cfg_flat)
    );

    irqf_target_or #(
        .STAT_W (STAT_W),
        .N_TGT  (N_TGT)
    ) u_tgt (
        .stat_i (stat_q),
        .cfg_i  (cfg_flat),
        .irq_o  (irq_o)
    );

    // Return the addressed register; unmapped addresses read zero.
    always_comb begin
        unique case (sel)
            SEL_STAT: reg_rdata_o = stat_q;
            SEL_CFG:  reg_rdata_o = cfg_flat[cfg_idx*STAT_W +: STAT_W];
            default:  reg_rdata_o = '0;
        endcase
    end

    // The GPIO position must not overlap the software bits.
    initial begin
        if ((GPIO_MASK & SW_MASK) != '0)
            $display("irq_fanout_ctrl: GPIO bit overlaps software bits");
    end
endmodule

// File: rtl/irqf_chk.sv
// Assertion checker for irq_fanout_ctrl, attached by bind.
// Observes the ports and the status/enable state of the top.
module irqf_chk #(
    parameter int STAT_W = 32,
    parameter int N_TGT  = 8,
    parameter int SW_LO  = 2,
    parameter int SW_N   = 2,
    parameter int ADDR_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_wr_i,
    input logic [ADDR_W-1:0]       reg_addr_i,
    input logic [STAT_W-1:0]       reg_wdata_i,
    input logic [STAT_W-1:0]       src_i,
    input logic [N_TGT-1:0]        irq_o,
    input logic [STAT_W-1:0]       stat_q,
    input logic [N_TGT*STAT_W-1:0] cfg_flat
);
    localparam logic [STAT_W-1:0] SWM =
        ((STAT_W'(1) << SW_N) - STAT_W'(1)) << SW_LO;

    logic unmapped_wr;
    logic status_zero_wr;
    always_comb begin
        unmapped_wr    = reg_wr_i && (reg_addr_i != '0) &&
                         (reg_addr_i < ADDR_W'(N_TGT));
        status_zero_wr = reg_wr_i && (reg_addr_i == '0) &&
                         ((reg_wdata_i & SWM) == '0);
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0)); // R1

    AST_HW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~SWM) == ($past(src_i) & ~SWM))); // R2

    AST_SW_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        status_zero_wr |=> ((stat_q & SWM) == '0)); // R4

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |=> $stable(cfg_flat)); // R6

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> (irq_o == '0)); // R7

    AST_UNMAPPED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_wr |=> ($stable(cfg_flat) && $stable(stat_q & SWM))); // R9
endmodule

bind irq_fanout_ctrl irqf_chk #(
    .STAT_W (STAT_W),
    .N_TGT  (N_TGT),
    .SW_LO  (SW_LO),
    .SW_N   (SW_N),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .src_i       (src_i),
    .irq_o       (irq_o),
    .stat_q      (stat_q),
    .cfg_flat    (cfg_flat)
);

// File: tb/irq_fanout_ctrl_tb.sv
module irq_fanout_ctrl_tb;
    localparam int SW = 32;
    localparam int NT = 8;
    localparam logic [31:0] SWM = 32'h0000_000C;
    localparam logic [31:0] HWM = ~SWM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [31:0] src_i = '0;
    logic [7:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_fanout_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .src_i(src_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic set_src(input logic [31:0] v);
        src_i = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] pat;
        @(negedge clk); @(negedge clk);
        // R1: reset state
        chk("R1 irq", {24'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int n = 0; n < NT; n++) begin
            rd(4'(8 + n), d);
            chk("R1 cfg", d, 32'h0);
        end
        rd(4'd0, d);
        chk("R1 status", d, 32'h0);

        // R6: each enable word holds its own value
        for (int n = 0; n < NT; n++) wr(4'(8 + n), 32'hA500_3C00 ^ (32'h0101_0101 * (n + 1)));
        for (int n = 0; n < NT; n++) begin
            rd(4'(8 + n), d);
            chk("R6 cfg readback", d, 32'hA500_3C00 ^ (32'h0101_0101 * (n + 1)));
        end
        for (int n = 0; n < NT; n++) wr(4'(8 + n), 32'h0);

        // R2, R5: walking one on the sources
        for (int i = 0; i < SW; i++) begin
            set_src(32'h1 << i);
            rd(4'd0, d);
            chk((i == 2 || i == 3) ? "R5 sw src ignored" : "R2 hw follow", d, (32'h1 << i) & HWM);
        end

        // R3, R4: status writes
        set_src(32'h8001_8013);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d);
        chk("R3 R4 set sw", d, (32'h8001_8013 & HWM) | SWM);
        wr(4'd0, 32'h0000_0004);
        rd(4'd0, d);
        chk("R4 load bit2", d, (32'h8001_8013 & HWM) | 32'h4);
        @(negedge clk);
        rd(4'd0, d);
        chk("R4 hold", d, (32'h8001_8013 & HWM) | 32'h4);
        wr(4'd0, 32'h0);
        rd(4'd0, d);
        chk("R3 R4 ack clears", d, 32'h8001_8013 & HWM);

        // R7: sweep outputs and bits
        for (int n = 0; n < NT; n++) begin
            for (int i = 0; i < SW; i++) begin
                pat = 32'h1 << i;
                wr(4'(8 + n), pat);
                if (i == 2 || i == 3) begin
                    set_src(32'h0);
                    wr(4'd0, pat);
                end else begin
                    set_src(pat);
                end
                chk("R7 hit", {24'h0, irq_o}, 32'h1 << n);
                wr(4'd0, 32'h0);
                set_src(~pat & HWM);
                chk("R7 miss", {24'h0, irq_o}, 32'h0);
            end
            wr(4'(8 + n), 32'h0);
        end

        // R5: source lines at software positions never raise an output
        for (int n = 0; n < NT; n++) wr(4'(8 + n), SWM);
        set_src(SWM);
        chk("R5 irq", {24'h0, irq_o}, 32'h0);

        // R8: GPIO routing per output
        for (int n = 0; n < NT; n++) wr(4'(8 + n), 32'h0000_8000);
        set_src(32'h0000_8000);
        chk("R8 all routed", {24'h0, irq_o}, 32'hFF);
        for (int n = 1; n < NT; n += 2) wr(4'(8 + n), 32'h0);
        chk("R8 odd removed", {24'h0, irq_o}, 32'h55);
        set_src(32'h0);
        chk("R8 gpio low", {24'h0, irq_o}, 32'h0);

        // R9: unmapped addresses
        wr(4'd0, 32'h8);
        for (int a = 1; a < 8; a++) wr(4'(a), 32'hFFFF_FFFF);
        for (int a = 1; a < 8; a++) begin
            rd(4'(a), d);
            chk("R9 read zero", d, 32'h0);
        end
        rd(4'd0, d);
        chk("R9 sw kept", d, 32'h8);
        for (int n = 0; n < NT; n++) begin
            rd(4'(8 + n), d);
            chk("R9 cfg kept", d, (n % 2 == 0) ? 32'h0000_8000 : 32'h0);
        end

        // R1: reset again clears state
        wr(4'(8), 32'hFFFF_FFFF);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 irq after reset", {24'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        rd(4'd8, d);
        chk("R1 cfg after reset", d, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule